// File: doc/BRIEF.md
# Dual-Modulus Programmable Frequency Divider

This block divides a fast input clock by a programmable ratio. A prescaler counts input clocks in groups of 8 or 9. A control counter tracks how many of those groups make up one divide cycle, and how many of them must use the longer length of 9. The ratio comes from a 12-bit word. The upper nine bits form the main field and the lower three bits form the swallow field. The ratio is the word value plus 8, which equals 8·(main+1) + swallow.

The output does not emit a pulse. Instead it changes level once at the end of every divide cycle. The spacing between any two successive transitions is therefore the selected ratio, and the output period is twice that ratio. The word is captured only on the clock edge that closes a cycle, so an external fractional-N controller can change it at any time without corrupting the cycle in progress.

A flag reports whether the word currently in use keeps the divider's internal state identical from one cycle to the next. That holds for ratios of 64 and above, and only those words are safe for fractional-N sequencing. Ratios from 56 to 63 are also exact. Below 56, only sparse groups of ratios can be reached, because the swallow count cannot exceed the number of prescaler groups.

Top module: `dms_divider`

## Requirements
- R1: For a word whose swallow field (bits 2:0) does not exceed main field (bits 11:3) plus one, the number of input clocks between successive output transitions equals the word value plus 8.
- R2: While the synchronous active-high reset is high, the output is driven low. Out of reset, the output changes level exactly once per divide cycle and holds steady between cycle ends.
- R3: The main and swallow inputs are sampled only on the edge that ends a divide cycle. A change made in the middle of a cycle leaves that cycle's length unchanged and takes effect in the following cycle.
- R4: The first cycle after reset release uses the word present at the last reset edge. Its output transition comes that ratio's number of clocks after release.
- R5: The safe flag is high exactly when the main field of the word in use is 7 or more (ratio 64 or above). It changes only at a cycle end, and it follows the inputs while reset is held.
- R6: With main fields 0 to 5 and swallow not above main plus one, the divider produces word plus 8. This gives the reachable small ratios 8–9, 16–18, 24–27, 32–36, 40–45 and 48–54.
- R7: A word whose swallow field is larger than main plus one gives a cycle of 9·(main+1) clocks, with the safe flag low.
- R8: The range ends are reachable: 56, 63, 64, 4096 and 4103 clocks per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| main_in | input | 9 | Main field of the division word (word bits 11:3) |
| swal_in | input | 3 | Swallow field of the division word (word bits 2:0) |
| div_out | output | 1 | Divided output, one level change per divide cycle |
| word_ok | output | 1 | High when the word in use is safe for fractional-N sequencing |

## Verification
A vector table covers words in both prescaler mixes: all groups of 8, all groups of 9, and mixed. It also covers the range ends and unrealisable words, so a wrong swallow count is distinguishable from a wrong group count. Random words in the safe range exercise the full main field. An exhaustive walk of the small main fields confirms which sparse ratios exist. A word change placed mid-cycle separates boundary sampling from continuous sampling. A reset-release test with an unsafe word shows both which word the first cycle uses and how the flag tracks the inputs while reset is held.

// File: rtl/dms_pkg.sv
package dms_pkg;

    localparam int unsigned MAIN_W_DEF = 9;
    localparam int unsigned SWAL_W_DEF = 3;

    // Prescaler length selector: base group or base+1 group
    typedef enum logic {
        MOD_BASE  = 1'b0,
        MOD_PLUS1 = 1'b1
    } mod_e;

    // Base prescaler length derived from the swallow field width
    function automatic int unsigned base_mod(input int unsigned sw);
        return 32'd1 << sw;
    endfunction

    // A word repeats its internal state only when every swallow value fits
    function automatic logic ratio_safe(input int unsigned main_val,
                                        input int unsigned sw);
        return main_val >= (base_mod(sw) - 32'd1);
    endfunction

endpackage

// File: rtl/dms_prescaler.sv
module dms_prescaler
    import dms_pkg::*;
#(
    parameter int unsigned SWAL_W = SWAL_W_DEF
) (
    input  logic clk,
    input  logic rst,
    input  mod_e mode,
    output logic pre_end
);
    localparam int unsigned P  = base_mod(SWAL_W);
    localparam int unsigned CW = SWAL_W + 1;
    localparam logic [CW-1:0] LAST_BASE = CW'(P - 1);
    localparam logic [CW-1:0] LAST_PLUS = CW'(P);

    logic [CW-1:0] cnt_q;

    always_comb begin
        pre_end = (cnt_q == ((mode == MOD_PLUS1) ? LAST_PLUS : LAST_BASE));
    end

    always_ff @(posedge clk) begin
        if (rst || pre_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/dms_ctrl_counter.sv
module dms_ctrl_counter
    import dms_pkg::*;
#(
    parameter int unsigned MAIN_W = MAIN_W_DEF,
    parameter int unsigned SWAL_W = SWAL_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pre_end,
    input  logic [MAIN_W-1:0] main_in,
    input  logic [SWAL_W-1:0] swal_in,
    output mod_e              mode,
    output logic              div_end,
    output logic [MAIN_W-1:0] main_q
);
    localparam int unsigned CNT_W = MAIN_W + 1;

    logic [CNT_W-1:0]  left_q;   // prescaler groups still to run, incl. current
    logic [SWAL_W-1:0] swal_q;   // long groups still to run

    always_comb begin
        div_end = pre_end && (left_q == CNT_W'(1));
        mode    = (swal_q != '0) ? MOD_PLUS1 : MOD_BASE;
    end

    always_ff @(posedge clk) begin
        if (rst || div_end) begin
            main_q <= main_in;
            left_q <= {1'b0, main_in} + CNT_W'(1);
            swal_q <= swal_in;
        end else if (pre_end) begin
            left_q <= left_q - CNT_W'(1);
            if (swal_q != '0) begin
                swal_q <= swal_q - SWAL_W'(1);
            end
        end
    end
endmodule

// File: rtl/dms_edge_out.sv
module dms_edge_out (
    input  logic clk,
    input  logic rst,
    input  logic div_end,
    output logic div_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            div_out <= 1'b0;
        end else if (div_end) begin
            div_out <= ~div_out;
        end
    end
endmodule

// File: rtl/dms_divider.sv
module dms_divider
    import dms_pkg::*;
#(
    parameter int unsigned MAIN_W = MAIN_W_DEF,
    parameter int unsigned SWAL_W = SWAL_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MAIN_W-1:0] main_in,
    input  logic [SWAL_W-1:0] swal_in,
    output logic              div_out,
    output logic              word_ok
);
    mod_e              mode;
    logic              pre_end;
    logic              div_end;
    logic [MAIN_W-1:0] main_q;

    dms_prescaler #(.SWAL_W(SWAL_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .pre_end (pre_end)
    );

    dms_ctrl_counter #(.MAIN_W(MAIN_W), .SWAL_W(SWAL_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .pre_end (pre_end),
        .main_in (main_in),
        .swal_in (swal_in),
        .mode    (mode),
        .div_end (div_end),
        .main_q  (main_q)
    );

    dms_edge_out u_out (
        .clk     (clk),
        .rst     (rst),
        .div_end (div_end),
        .div_out (div_out)
    );

    always_comb begin
        word_ok = ratio_safe(32'(main_q), SWAL_W);
    end
endmodule

// File: rtl/dms_divider_chk.sv
module dms_divider_chk #(
    parameter int unsigned MAIN_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              pre_end,
    input logic              div_end,
    input logic              div_out,
    input logic              word_ok,
    input logic [MAIN_W-1:0] main_q
);
    p_reset_low_r2: assert property (@(posedge clk)
        rst |=> !div_out);

    p_toggle_at_end_r2: assert property (@(posedge clk) disable iff (rst)
        div_end |=> (div_out != $past(div_out)));

    p_hold_mid_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        !div_end |=> $stable(div_out));

    p_shadow_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !div_end |=> $stable(main_q));

    p_flag_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !div_end |=> $stable(word_ok));

    p_end_on_group_r1: assert property (@(posedge clk) disable iff (rst)
        div_end |-> pre_end);

    p_group_gap_r1: assert property (@(posedge clk) disable iff (rst)
        pre_end |=> !pre_end);
endmodule

bind dms_divider dms_divider_chk #(.MAIN_W(MAIN_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pre_end (pre_end),
    .div_end (div_end),
    .div_out (div_out),
    .word_ok (word_ok),
    .main_q  (main_q)
);

// File: tb/tb_dms_divider.sv
module tb_dms_divider;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] main_in = 9'd7;
    logic [2:0] swal_in = 3'd3;
    logic       div_out;
    logic       word_ok;

    int n_checks = 0;
    int n_errs   = 0;
    logic last_out = 1'b0;
    bit   done = 1'b0;

    dms_divider dut (
        .clk     (clk),
        .rst     (rst),
        .main_in (main_in),
        .swal_in (swal_in),
        .div_out (div_out),
        .word_ok (word_ok)
    );

    always #5 clk = ~clk;

    // {main, swallow, expected clocks per cycle, expected flag}
    localparam int NV = 12;
    localparam logic [25:0] VEC [NV] = '{
        {9'd7,   3'd0, 13'd64,   1'b1},
        {9'd7,   3'd7, 13'd71,   1'b1},
        {9'd6,   3'd0, 13'd56,   1'b0},
        {9'd511, 3'd7, 13'd4103, 1'b1},
        {9'd100, 3'd3, 13'd811,  1'b1},
        {9'd255, 3'd0, 13'd2048, 1'b1},
        {9'd2,   3'd5, 13'd27,   1'b0},
        {9'd0,   3'd7, 13'd9,    1'b0},
        {9'd1,   3'd3, 13'd18,   1'b0},
        {9'd511, 3'd0, 13'd4096, 1'b1},
        {9'd8,   3'd1, 13'd73,   1'b1},
        {9'd63,  3'd4, 13'd516,  1'b1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count falling edges until the output changes level
    task automatic next_toggle(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (div_out == last_out && n < 10000);
        if (div_out == last_out) begin
            n_errs++;
            $display("FAIL R2: no transition, actual %0d clocks expected <10000", n);
        end
        last_out = div_out;
    endtask

    task automatic run_word(input logic [8:0] m, input logic [2:0] a,
                            input int exp, input bit exp_ok, input string req);
        int n;
        main_in = m;
        swal_in = a;
        next_toggle(n);                       // boundary that captures the word
        check(word_ok == exp_ok, "R5", int'(word_ok), int'(exp_ok));
        next_toggle(n);
        check(n == exp, req, n, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual 200000 cycles expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        int n;
        // Reset state and flag tracking while reset is held
        repeat (3) @(negedge clk);
        check(div_out == 1'b0, "R2", int'(div_out), 0);
        check(word_ok == 1'b1, "R5", int'(word_ok), 1);
        main_in = 9'd2; swal_in = 3'd5;
        @(negedge clk);
        check(word_ok == 1'b0, "R7", int'(word_ok), 0);
        // R4: word present at release is used by the first cycle
        main_in = 9'd6; swal_in = 3'd7;
        @(negedge clk);
        rst = 1'b0;
        last_out = 1'b0;
        next_toggle(n);
        check(n == 63, "R4", n, 63);
        check(word_ok == 1'b0, "R5", int'(word_ok), 0);
        check(div_out == 1'b1, "R2", int'(div_out), 1);

        // Table walk (R1, R7 and range ends R8)
        for (int i = 0; i < NV; i++) begin
            logic [8:0]  m;
            logic [2:0]  a;
            logic [12:0] e;
            logic        ok;
            string       tag;
            {m, a, e, ok} = VEC[i];
            if (int'(a) > int'(m) + 1) tag = "R7";
            else if (e == 56 || e == 63 || e == 64 || e == 4096 || e == 4103) tag = "R8";
            else tag = "R1";
            run_word(m, a, int'(e), ok, tag);
        end

        // Random safe words (R1)
        for (int i = 0; i < 10; i++) begin
            int m;
            int a;
            m = int'($urandom_range(511, 7));
            a = int'($urandom_range(7, 0));
            run_word(9'(m), 3'(a), 8 * m + a + 8, 1'b1, "R1");
        end

        // Sparse small ratios (R6)
        for (int m = 0; m < 6; m++) begin
            for (int a = 0; a <= m + 1; a++) begin
                run_word(9'(m), 3'(a), 8 * m + a + 8, 1'b0, "R6");
            end
        end

        // Mid-cycle change (R3): current cycle keeps old word
        main_in = 9'd20; swal_in = 3'd2;
        next_toggle(n);
        repeat (5) @(negedge clk);
        main_in = 9'd9; swal_in = 3'd4;
        next_toggle(n);
        check(n + 5 == 170, "R3", n + 5, 170);
        next_toggle(n);
        check(n == 84, "R3", n, 84);

        // Reset mid-cycle drives output low (R2)
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(div_out == 1'b0, "R2", int'(div_out), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule